// File: doc/BRIEF.md
# Output Fault and Power-Good Supervisor

This block watches a buck regulator's output through a digitized feedback code, given in millivolts at the feedback node, and a strobe that pulses once per switching cycle. From these it decides whether the output is good and latches two kinds of fault. An over-voltage fault forces the low-side switch on. An under-voltage fault turns both gate drives off. It also drives the pull-down that selects between two output set-points, and it handles the transition that follows a change of that select.

A change of the select input opens a window that lasts a fixed number of switching cycles. During the window, power-good is frozen at its present value and the over-voltage limit is raised, so that the step at the feedback node does not trip anything while the output slews to its new level. Once latched, a fault is cleared only by dropping the enable or by the synchronous reset. Time filters are counted in clock ticks and under-voltage persistence is counted in strobes.

Top module: `outsup_top`

## Requirements
- R1: The power-good window is inclusive. Feedback from 600 to 900 mV counts as in-window, and any code below 600 or above 900 counts as out-of-window.
- R2: The internal good state changes only after the window condition has differed from it on FILT_TICKS consecutive clocks. The `pgood` output follows on the next clock. A shorter excursion has no effect on `pgood`.
- R3: `pgood` stays 0 until soft-start has completed. Completion means that `ss_done` is 1 and feedback is at or above 750 mV while enabled. `pgood` is also 0 while any fault is latched.
- R4: Outside a select window, feedback above 900 mV that persists for FILT_TICKS consecutive clocks latches the over-voltage fault on the following clock. `ov_lowside_on` then goes to 1. A code of exactly 900 never trips.
- R5: Once soft-start has completed, feedback below 525 mV on UV_CYCLES consecutive strobes latches the under-voltage fault, and `uv_drive_off` goes to 1. A strobe that samples 525 mV or more restarts the count. Before soft-start completes, low feedback is ignored.
- R6: A latched fault holds until `enable` is 0 for a clock or reset is applied. While one fault is latched, the other cannot latch.
- R7: `sel_pulldown` is the inverse of `sel_in` with no clock delay, so a low select turns the pull-down on.
- R8: Any edge on `sel_in` freezes `pgood` at its present value for WIN_CYCLES strobes. The freeze ends with the last of those strobes.
- R9: During a select window, the over-voltage limit is 1125 mV. After the window ends, the limit returns to 900 mV.
- R10: A select edge inside an active window restarts the window with a full WIN_CYCLES count.
- R11: While `enable` is 0, `pgood` is 0, both faults are clear and soft-start completion is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on reset) |
| enable | input | 1 | Controller enable; a low level clears faults |
| ss_done | input | 1 | Soft-start ramp has reached its final reference |
| cyc_stb | input | 1 | One-clock pulse per switching cycle |
| sel_in | input | 1 | Output set-point select |
| fb_mv | input | FB_W | Feedback voltage code in millivolts |
| pgood | output | 1 | Power-good, 1 = good |
| ov_lowside_on | output | 1 | Over-voltage fault latched; forces low-side switch on |
| uv_drive_off | output | 1 | Under-voltage fault latched; both drives off |
| sel_pulldown | output | 1 | Set-point pull-down switch on |

## Verification
The bench sweeps feedback codes around each boundary (599/600, 900/901, 524/525) and checks the exact clock on which `pgood` and the faults move. A filter that is off by one would flip a clock early or late. An excursion that ends one tick short must leave `pgood` untouched; a filter that does not restart its count would drop it. Select windows are run with feedback placed where it would otherwise pull `pgood` down and trip the 900 mV limit. The bench also runs a second edge in the middle of a window, and a window that ended too early or failed to restart would show a premature fault. An under-voltage count that is broken by a single good strobe, and low feedback before soft-start completes, catch a counter that never clears or that is armed too soon.

// File: rtl/outsup_pkg.sv
// Package: shared types for the output supervisor.
// Assumes: nothing beyond standard SystemVerilog.
package outsup_pkg;
    // Latched fault pair; at most one bit is ever set.
    typedef struct packed {
        logic ov;
        logic uv;
    } fault_t;
endpackage

// File: rtl/outsup_persist.sv
// Persistence filter: out takes the value of raw only after raw has
// differed from out on TICKS consecutive clocks.
// Assumes: TICKS >= 1; clr is a synchronous clear forcing out to 0.
module outsup_persist #(
    parameter int TICKS = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw,
    output logic filt
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive disagreeing clocks and flip on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            filt    <= 1'b0;
            run_cnt <= '0;
        end else if (raw == filt) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            filt    <= raw;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R2: the filtered value only ever moves toward the raw input.
    a_r2_moves_to_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !$stable(filt) && filt) |-> $past(raw));
endmodule

// File: rtl/outsup_selwin.sv
// Select-transition window: detects any edge on the select input and
// keeps a window open for WIN strobes; a new edge restarts it.
// Assumes: sel_in is synchronous to clk.
module outsup_selwin #(
    parameter int WIN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_in,
    input  logic cyc_stb,
    output logic sel_edge,
    output logic win_open
);
    localparam int WW = $clog2(WIN + 1);
    localparam logic [WW-1:0] FULL = WW'(WIN);

    logic          sel_q;
    logic [WW-1:0] win_left;

    assign sel_edge = sel_in ^ sel_q;
    assign win_open = (win_left != '0);

    // Track previous select level; reset loads the present level.
    always_ff @(posedge clk) begin
        sel_q <= sel_in;
    end

    // Window countdown: an edge reloads, each strobe consumes one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_left <= '0;
        end else if (sel_edge) begin
            win_left <= FULL;
        end else if (cyc_stb && win_open) begin
            win_left <= win_left - 1'b1;
        end
    end

    // R10: any edge leaves the window fully loaded next clock.
    a_r10_edge_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        sel_edge |=> (win_left == FULL));
    // R8: without a strobe or an edge the window count does not move.
    a_r8_holds_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_edge && !cyc_stb) |=> $stable(win_left));
endmodule

// File: rtl/outsup_uvcount.sv
// Under-voltage persistence counter: counts strobes that sample feedback
// below the limit; any good strobe restarts the count.
// Assumes: arm low holds the count at zero.
module outsup_uvcount #(
    parameter int FB_W      = 12,
    parameter int UV_MV     = 525,
    parameter int UV_CYCLES = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            cyc_stb,
    input  logic [FB_W-1:0] fb_mv,
    output logic            uv_trip
);
    localparam int CW = (UV_CYCLES > 1) ? $clog2(UV_CYCLES) : 1;
    localparam logic [CW-1:0]   LAST  = CW'(UV_CYCLES - 1);
    localparam logic [FB_W-1:0] LIMIT = FB_W'(UV_MV);

    logic [CW-1:0] low_cnt;
    logic          below;

    assign below   = (fb_mv < LIMIT);
    assign uv_trip = arm && cyc_stb && below && (low_cnt == LAST);

    // Count consecutive low strobes while armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            low_cnt <= '0;
        end else if (cyc_stb) begin
            if (!below || uv_trip) low_cnt <= '0;
            else                   low_cnt <= low_cnt + 1'b1;
        end
    end

    // R5: a strobe at or above the limit leaves the count at zero.
    a_r5_good_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !below) |=> (low_cnt == '0));
endmodule

// File: rtl/outsup_top.sv
// Output supervisor top: power-good decision, over/under-voltage fault
// latches and set-point select handling around a select transition.
// Assumes: fb_mv is a millivolt code sampled every clock; cyc_stb is a
// single-clock pulse per switching cycle; rst_n is the power-on reset.
module outsup_top #(
    parameter int FB_W       = 12,
    parameter int FILT_TICKS = 1250,
    parameter int WIN_CYCLES = 32,
    parameter int UV_CYCLES  = 8,
    parameter int REF_MV     = 750,
    parameter int PG_LO_MV   = 600,
    parameter int OV_MV      = 900,
    parameter int OV_WIN_MV  = 1125,
    parameter int UV_MV      = 525
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            ss_done,
    input  logic            cyc_stb,
    input  logic            sel_in,
    input  logic [FB_W-1:0] fb_mv,
    output logic            pgood,
    output logic            ov_lowside_on,
    output logic            uv_drive_off,
    output logic            sel_pulldown
);
    import outsup_pkg::*;

    localparam logic [FB_W-1:0] REF_C   = FB_W'(REF_MV);
    localparam logic [FB_W-1:0] PGLO_C  = FB_W'(PG_LO_MV);
    localparam logic [FB_W-1:0] OV_C    = FB_W'(OV_MV);
    localparam logic [FB_W-1:0] OVWIN_C = FB_W'(OV_WIN_MV);

    fault_t          fault;
    logic            started;
    logic            sel_edge, win_open, freeze;
    logic [FB_W-1:0] ov_limit;
    logic            pg_raw, pg_filt, ov_raw, ov_filt, uv_trip;

    assign sel_pulldown  = ~sel_in;
    assign freeze        = sel_edge | win_open;
    assign ov_limit      = win_open ? OVWIN_C : OV_C;
    assign pg_raw        = (fb_mv >= PGLO_C) && (fb_mv <= OV_C);
    assign ov_raw        = (fb_mv > ov_limit);
    assign ov_lowside_on = fault.ov;
    assign uv_drive_off  = fault.uv;

    outsup_selwin #(.WIN(WIN_CYCLES)) u_selwin (
        .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .cyc_stb(cyc_stb),
        .sel_edge(sel_edge), .win_open(win_open)
    );

    outsup_persist #(.TICKS(FILT_TICKS)) u_pg_filt (
        .clk(clk), .rst_n(rst_n), .clr(!enable), .raw(pg_raw), .filt(pg_filt)
    );

    outsup_persist #(.TICKS(FILT_TICKS)) u_ov_filt (
        .clk(clk), .rst_n(rst_n), .clr(!enable), .raw(ov_raw), .filt(ov_filt)
    );

    outsup_uvcount #(.FB_W(FB_W), .UV_MV(UV_MV), .UV_CYCLES(UV_CYCLES)) u_uv (
        .clk(clk), .rst_n(rst_n), .arm(started && (fault == '0)),
        .cyc_stb(cyc_stb), .fb_mv(fb_mv), .uv_trip(uv_trip)
    );

    // Remember that soft-start finished at the reference level.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)              started <= 1'b0;
        else if (ss_done && fb_mv >= REF_C) started <= 1'b1;
    end

    // Fault latch: first fault wins; cleared only by disable or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            fault <= '0;
        end else if (fault == '0) begin
            if (ov_filt)      fault.ov <= 1'b1;
            else if (uv_trip) fault.uv <= 1'b1;
        end
    end

    // Power-good output: forced low, frozen in a window, else filtered.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)                pgood <= 1'b0;
        else if (!started || fault != '0)     pgood <= 1'b0;
        else if (!freeze)                     pgood <= pg_filt;
    end

    // R3: a latched over-voltage fault drives power-good low next clock.
    a_r3_fault_drops_pgood: assert property (@(posedge clk) disable iff (!rst_n)
        (fault != '0) |=> !pgood);
    // R6: the two faults are never latched together.
    a_r6_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ov_lowside_on, uv_drive_off}));
    // R6: a fault does not clear while enabled.
    a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ov_lowside_on) |=> ov_lowside_on);
    // R11: disable clears everything on the next clock.
    a_r11_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pgood && !ov_lowside_on && !uv_drive_off));
    // R8: in a window with no fault, power-good holds its value.
    a_r8_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && started && fault == '0 && freeze) |=> $stable(pgood));
    // R4: over-voltage latches only after its filter has asserted.
    a_r4_ov_needs_filter: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov_lowside_on) |-> $past(ov_filt));
    // R5: under-voltage latches only on a low strobe.
    a_r5_uv_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uv_drive_off) |-> $past(cyc_stb && fb_mv < FB_W'(UV_MV)));
endmodule

// File: tb/outsup_top_bench.sv
module outsup_top_bench;
    localparam int FB_W = 12;
    localparam int FILT = 8;
    localparam int WIN  = 32;
    localparam int UVC  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, enable = 1'b0, ss_done = 1'b0, cyc_stb = 1'b0, sel_in = 1'b1;
    logic [FB_W-1:0] fb_mv = '0;
    logic pgood, ov_lowside_on, uv_drive_off, sel_pulldown;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    outsup_top #(.FB_W(FB_W), .FILT_TICKS(FILT), .WIN_CYCLES(WIN), .UV_CYCLES(UVC)) u_outsup_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ss_done(ss_done),
        .cyc_stb(cyc_stb), .sel_in(sel_in), .fb_mv(fb_mv), .pgood(pgood),
        .ov_lowside_on(ov_lowside_on), .uv_drive_off(uv_drive_off),
        .sel_pulldown(sel_pulldown)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_stb = 1'b1;
            step(1);
            cyc_stb = 1'b0;
            step(3);
        end
    endtask

    task automatic check(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // Bring the supply up: enable, soft-start done at 760 mV, filter settled.
    task automatic bring_up();
        enable = 1'b1; ss_done = 1'b1; fb_mv = 12'd760;
        step(FILT + 2);
        fb_mv = 12'd700;
        step(2);
    endtask

    task automatic toggle_enable();
        enable = 1'b0;
        step(1);
    endtask

    initial begin
        step(3);
        check("R11 reset pgood", pgood, 1'b0);
        check("R6 reset ov", ov_lowside_on, 1'b0);
        check("R6 reset uv", uv_drive_off, 1'b0);
        check("R7 reset pulldown", sel_pulldown, 1'b0);
        rst_n = 1'b1;

        // R3: no pgood before soft-start completion at the reference.
        enable = 1'b1; fb_mv = 12'd700;
        step(20);
        check("R3 before ss_done", pgood, 1'b0);
        ss_done = 1'b1; fb_mv = 12'd740;
        step(5);
        check("R3 below reference", pgood, 1'b0);
        fb_mv = 12'd750;
        step(1);
        check("R3 started latency", pgood, 1'b0);
        step(1);
        check("R3 pgood after start", pgood, 1'b1);
        fb_mv = 12'd700;

        // R1 R2: lower boundary with exact filter timing.
        fb_mv = 12'd599;
        step(FILT);
        check("R2 599 not yet", pgood, 1'b1);
        step(1);
        check("R1 599 out of window", pgood, 1'b0);
        fb_mv = 12'd700;
        step(FILT);
        check("R2 return not yet", pgood, 1'b0);
        step(1);
        check("R2 return good", pgood, 1'b1);
        fb_mv = 12'd600;
        step(12);
        check("R1 600 in window", pgood, 1'b1);
        fb_mv = 12'd900;
        step(12);
        check("R1 900 in window", pgood, 1'b1);
        check("R4 900 no trip", ov_lowside_on, 1'b0);

        // R2: excursion one tick short is ignored.
        fb_mv = 12'd599;
        step(FILT - 1);
        fb_mv = 12'd700;
        step(12);
        check("R2 short glitch ignored", pgood, 1'b1);

        // R4: 901 trips over-voltage after the filter.
        fb_mv = 12'd901;
        step(FILT);
        check("R4 901 not yet", ov_lowside_on, 1'b0);
        step(1);
        check("R4 901 trips", ov_lowside_on, 1'b1);
        check("R1 901 out of window", pgood, 1'b0);
        fb_mv = 12'd700;
        step(10);
        check("R6 ov sticky", ov_lowside_on, 1'b1);
        check("R3 low after fault", pgood, 1'b0);
        toggle_enable();
        check("R6 ov cleared by enable", ov_lowside_on, 1'b0);
        check("R11 pgood low disabled", pgood, 1'b0);
        bring_up();
        check("R3 pgood back", pgood, 1'b1);

        // R7 R8 R9: select edge freezes pgood and lifts the limit.
        sel_in = 1'b0;
        #1;
        check("R7 pulldown immediate", sel_pulldown, 1'b1);
        step(1);
        fb_mv = 12'd1000;
        strobe(WIN - 1);
        check("R8 pgood frozen", pgood, 1'b1);
        check("R9 raised limit no trip", ov_lowside_on, 1'b0);
        strobe(1);
        check("R8 freeze released", pgood, 1'b0);
        check("R9 still clear at end", ov_lowside_on, 1'b0);
        step(5);
        check("R9 normal limit not yet", ov_lowside_on, 1'b0);
        step(1);
        check("R9 normal limit trips", ov_lowside_on, 1'b1);
        toggle_enable();
        bring_up();

        // R10: a second edge restarts the window.
        sel_in = 1'b1;
        #1;
        check("R7 pulldown off", sel_pulldown, 1'b0);
        step(1);
        strobe(20);
        sel_in = 1'b0;
        step(1);
        fb_mv = 12'd1000;
        strobe(WIN - 1);
        check("R10 window restarted pgood", pgood, 1'b1);
        check("R10 window restarted ov", ov_lowside_on, 1'b0);
        strobe(1);
        check("R10 window ends", pgood, 1'b0);
        step(FILT);
        toggle_enable();
        bring_up();

        // R9: above 1125 trips even inside the window.
        sel_in = 1'b1;
        step(1);
        fb_mv = 12'd1126;
        step(FILT);
        check("R9 1126 not yet", ov_lowside_on, 1'b0);
        step(1);
        check("R9 1126 trips in window", ov_lowside_on, 1'b1);
        step(1);
        check("R3 fault overrides freeze", pgood, 1'b0);
        strobe(WIN);
        toggle_enable();
        bring_up();

        // R5: under-voltage count with a restart by one good strobe.
        fb_mv = 12'd524;
        strobe(UVC - 1);
        fb_mv = 12'd525;
        strobe(1);
        fb_mv = 12'd524;
        strobe(UVC - 1);
        check("R5 count restarted", uv_drive_off, 1'b0);
        strobe(1);
        check("R5 uv trips", uv_drive_off, 1'b1);
        fb_mv = 12'd1200;
        step(FILT + 4);
        check("R6 ov blocked by uv", ov_lowside_on, 1'b0);
        check("R6 uv sticky", uv_drive_off, 1'b1);
        toggle_enable();
        check("R6 uv cleared by enable", uv_drive_off, 1'b0);

        // R5: low feedback before soft-start completes is ignored.
        enable = 1'b1; ss_done = 1'b0; fb_mv = 12'd400;
        strobe(UVC + 4);
        check("R5 ignored before start", uv_drive_off, 1'b0);
        check("R3 no pgood before start", pgood, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule